// File: doc/BRIEF.md
# Memory-to-Memory Two-Operand Adder Sequencer

This block carries out one two-address add instruction against a single-port synchronous memory. When it accepts a start request, it takes in an instruction word that names two memory addresses, A and B. It then runs a fixed execute sequence of three memory references inside one instruction cycle. First it reads location A into one operand register. Next it reads location B into a second operand register, so the first value is kept. It adds the two values and writes the sum back to location A.

The memory port has one cycle of read latency. After each read address is issued, the sequencer spends one idle cycle and then captures the returned word. A single-cycle done pulse marks the end of the instruction. While an instruction is in flight, start requests are ignored.

Top module: `m2m_add_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `done_o`, `mem_req_o` and `mem_we_o` are low.
- R2: The instruction is captured only in the cycle a start is accepted. Address A is `instr_i[23:12]` and address B is `instr_i[11:0]`. Later changes on `instr_i` do not change the addresses used.
- R3: In the first cycle after acceptance, the block issues a read of address A (`mem_req_o`=1, `mem_we_o`=0, `mem_addr_o`=A).
- R4: Each read is followed by one cycle with no memory access. The read of address B is issued in the third cycle after acceptance.
- R5: In the sixth cycle after acceptance, the block writes to address A (`mem_req_o`=1, `mem_we_o`=1). The write data is the word returned for A plus the word returned for B.
- R6: An instruction makes exactly three memory accesses, in the order read A, read B, write A. When A differs from B, location B keeps its value.
- R7: `done_o` is high for exactly one cycle, the seventh cycle after acceptance, which directly follows the write. It is low at all other times.
- R8: A start is accepted only when the block is idle. Starts raised in any cycle from acceptance through the done cycle have no effect.
- R9: When A equals B, the location ends up holding twice its original value, modulo 2^16.
- R10: The sum is 16 bits wide and wraps modulo 2^16. Any carry out is dropped.
- R11: A start raised in the cycle right after the done pulse is accepted, so instructions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| instr_i | input | 24 | Instruction: address A in [23:12], address B in [11:0] |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Write enable, valid with `mem_req_o` |
| mem_addr_o | output | 12 | Memory address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the read address |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that the access pattern is well formed:
- the first access after acceptance is a read at the captured A address;
- every read is followed by a quiet cycle;
- every write goes to the address read five cycles earlier and carries the sum of the two returned words;
- done is a single-cycle pulse that directly follows a write;
- no access or done appears while the block is idle.

Only the bench scenarios can show the effect on memory contents: the final value at A, B left untouched, the doubling when A equals B, and wrap-around of large operands. The same holds for starts raised mid-instruction, which must leave the access count at three, and for back-to-back acceptance right after done.

// File: rtl/m2m_add_pkg.sv
package m2m_add_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_WT_A,
    ST_RD_B,
    ST_WT_B,
    ST_ADD,
    ST_WR_A,
    ST_DONE
  } seq_state_e;

  localparam int unsigned NUM_OPND = 2;
  localparam int unsigned OPND_A   = 0;
  localparam int unsigned OPND_B   = 1;
endpackage

// File: rtl/m2m_add_ctrl.sv
module m2m_add_ctrl
  import m2m_add_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic                accept_o,
  output logic                rd_a_o,
  output logic                rd_b_o,
  output logic [NUM_OPND-1:0] cap_o,
  output logic                add_o,
  output logic                wr_o,
  output logic                done_o,
  output logic                busy_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RD_A;
      ST_RD_A: state_d = ST_WT_A;
      ST_WT_A: state_d = ST_RD_B;
      ST_RD_B: state_d = ST_WT_B;
      ST_WT_B: state_d = ST_ADD;
      ST_ADD:  state_d = ST_WR_A;
      ST_WR_A: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    accept_o       = (state_q == ST_IDLE) && start_i;
    rd_a_o         = (state_q == ST_RD_A);
    rd_b_o         = (state_q == ST_RD_B);
    cap_o          = '0;
    cap_o[OPND_A]  = (state_q == ST_WT_A);
    cap_o[OPND_B]  = (state_q == ST_WT_B);
    add_o          = (state_q == ST_ADD);
    wr_o           = (state_q == ST_WR_A);
    done_o         = (state_q == ST_DONE);
    busy_o         = (state_q != ST_IDLE);
  end
endmodule

// File: rtl/m2m_add_dpath.sv
module m2m_add_dpath
  import m2m_add_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned INSTR_W = 2 * ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [NUM_OPND-1:0] cap_i,
  input  logic                add_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic [ADDR_W-1:0]   addr_a_o,
  output logic [ADDR_W-1:0]   addr_b_o,
  output logic [DATA_W-1:0]   sum_o
);
  logic [INSTR_W-1:0]               ir_q;
  logic [NUM_OPND-1:0][DATA_W-1:0]  opnd_q;
  logic [DATA_W-1:0]                sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ir_q <= '0;
    else if (accept_i) ir_q <= instr_i;
  end

  assign addr_a_o = ir_q[INSTR_W-1 -: ADDR_W];
  assign addr_b_o = ir_q[ADDR_W-1:0];

  // separate holding register per operand so A survives the B read
  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       opnd_q[g] <= '0;
      else if (cap_i[g]) opnd_q[g] <= rdata_i;
    end
  end

  // carry out discarded: modulo 2^DATA_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (add_i) sum_q <= opnd_q[OPND_A] + opnd_q[OPND_B];
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/m2m_add_memif.sv
module m2m_add_memif #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              rd_a_i,
  input  logic              rd_b_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [DATA_W-1:0] sum_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_comb begin
    req_o   = rd_a_i | rd_b_i | wr_i;
    we_o    = wr_i;
    addr_o  = '0;
    if (rd_a_i || wr_i) addr_o = addr_a_i;
    else if (rd_b_i)    addr_o = addr_b_i;
    wdata_o = wr_i ? sum_i : '0;
  end
endmodule

// File: rtl/m2m_add_seq.sv
module m2m_add_seq
  import m2m_add_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned INSTR_W = 2 * ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               done_o
);
  logic                accept, rd_a, rd_b, add, wr, seq_busy;
  logic [NUM_OPND-1:0] cap;
  logic [ADDR_W-1:0]   addr_a, addr_b;
  logic [DATA_W-1:0]   sum;

  m2m_add_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .rd_a_o   (rd_a),
    .rd_b_o   (rd_b),
    .cap_o    (cap),
    .add_o    (add),
    .wr_o     (wr),
    .done_o   (done_o),
    .busy_o   (seq_busy)
  );

  m2m_add_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .instr_i  (instr_i),
    .cap_i    (cap),
    .add_i    (add),
    .rdata_i  (mem_rdata_i),
    .addr_a_o (addr_a),
    .addr_b_o (addr_b),
    .sum_o    (sum)
  );

  m2m_add_memif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_memif (
    .rd_a_i   (rd_a),
    .rd_b_i   (rd_b),
    .wr_i     (wr),
    .addr_a_i (addr_a),
    .addr_b_i (addr_b),
    .sum_i    (sum),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .wdata_o  (mem_wdata_o)
  );
endmodule

// File: rtl/m2m_add_seq_chk.sv
module m2m_add_seq_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned INSTR_W = 2 * ADDR_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic [DATA_W-1:0]  mem_wdata_o,
  input logic [DATA_W-1:0]  mem_rdata_i,
  input logic               done_o,
  input logic               busy
);
  AST_FIRST_READ_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i) |=> (mem_req_o && !mem_we_o &&
      mem_addr_o == $past(instr_i[INSTR_W-1 -: ADDR_W]))); // R3

  AST_READ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !mem_req_o); // R4

  AST_WRITE_ADDR_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && $past(mem_req_o, 5) && !$past(mem_we_o, 5) &&
      mem_addr_o == $past(mem_addr_o, 5))); // R5

  AST_WRITE_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == DATA_W'($past(mem_rdata_i, 4) + $past(mem_rdata_i, 2)))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_we_o) && !mem_req_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mem_req_o && !done_o)); // R8
endmodule

bind m2m_add_seq m2m_add_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .instr_i     (instr_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .done_o      (done_o),
  .busy        (seq_busy)
);

// File: tb/m2m_add_seq_tb_top.sv
module m2m_add_seq_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 16;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2*AW-1:0] instr = '0;
  logic          req, we, done;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata = '0;

  logic [DW-1:0] mem_q [DEPTH];
  logic          tb_wr = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [DW-1:0] tb_data = '0;
  int unsigned   acc_cnt = 0;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  m2m_add_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .instr_i     (instr),
    .mem_req_o   (req),
    .mem_we_o    (we),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .mem_rdata_i (rdata),
    .done_o      (done)
  );

  // single-port memory model, one cycle read latency
  always @(posedge clk) begin
    if (tb_wr) mem_q[tb_addr] <= tb_data;
    else if (req && we) mem_q[addr] <= wdata;
    if (req && !we) rdata <= mem_q[addr];
    if (req) acc_cnt <= acc_cnt + 1;
  end

  function automatic logic [DW-1:0] exp_sum(logic [DW-1:0] x, logic [DW-1:0] y);
    logic [DW:0] full;
    full = {1'b0, x} + {1'b0, y};
    return full[DW-1:0];
  endfunction

  task automatic check(bit ok, string req_tag, string what, longint act, longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, expv);
    end
  endtask

  task automatic poke(logic [AW-1:0] a, logic [DW-1:0] v);
    tb_wr = 1'b1; tb_addr = a; tb_data = v;
    @(negedge clk);
    tb_wr = 1'b0;
  endtask

  // called just after a negedge; returns at a negedge with start low
  task automatic run_instr(logic [AW-1:0] a, logic [AW-1:0] b, bit ign, string tag);
    logic [DW-1:0] va, vb, ex;
    int unsigned c0;
    va = mem_q[a]; vb = mem_q[b]; ex = exp_sum(va, vb);
    c0 = acc_cnt;
    start = 1'b1; instr = {a, b};
    @(negedge clk);
    if (ign) instr = ~{a, b};
    else begin start = 1'b0; instr = {b, a}; end
    check(req && !we && addr == a, "R3", "read A", {req, we, addr}, {2'b10, a});
    @(negedge clk);
    check(!req, "R4", "gap after A", req, 0);
    @(negedge clk);
    check(req && !we && addr == b, "R4", "read B (R2 addr kept)", {req, we, addr}, {2'b10, b});
    @(negedge clk);
    check(!req, "R4", "gap after B", req, 0);
    @(negedge clk);
    check(!req && !done, "R7", "quiet add cycle", {req, done}, 0);
    @(negedge clk);
    check(req && we && addr == a, "R5", "write A", {req, we, addr}, {2'b11, a});
    check(wdata == ex, tag, "write data", wdata, ex);
    @(negedge clk);
    check(done && !req, "R7", "done pulse", {done, req}, 2'b10);
    @(negedge clk);
    start = 1'b0;
    check(!done && !req, ign ? "R8" : "R7", "idle after done", {done, req}, 0);
    check(mem_q[a] == ex, tag, "stored sum", mem_q[a], ex);
    if (a != b) check(mem_q[b] == vb, "R6", "B unchanged", mem_q[b], vb);
    check(acc_cnt - c0 == 3, ign ? "R8" : "R6", "access count", acc_cnt - c0, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    check(!done && !req && !we, "R1", "in reset", {done, req, we}, 0);
    for (int i = 0; i < DEPTH; i++) poke(AW'(i), DW'(i * 40503) ^ 16'h5a5a);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !req && !we, "R1", "after reset", {done, req, we}, 0);

    poke(12'h00a, 16'h0003); poke(12'h014, 16'h0004);
    run_instr(12'h00a, 12'h014, 1'b0, "R5");
    poke(12'h100, 16'hffff); poke(12'h101, 16'h0003);
    run_instr(12'h100, 12'h101, 1'b0, "R10");
    poke(12'h200, 16'h1234);
    run_instr(12'h200, 12'h200, 1'b0, "R9");
    poke(12'h201, 16'h8001);
    run_instr(12'h201, 12'h201, 1'b0, "R9");
    run_instr(12'h000, 12'hfff, 1'b0, "R5");
    run_instr(12'h0f0, 12'h0f1, 1'b1, "R8");
    // back to back: next start raised in the cycle after done
    run_instr(12'h300, 12'h301, 1'b0, "R5");
    run_instr(12'h301, 12'h300, 1'b0, "R11");

    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] ra, rb;
      ra = AW'($urandom);
      rb = ($urandom % 5 == 0) ? ra : AW'($urandom);
      if ($urandom % 3 == 0) begin
        poke(ra, DW'($urandom));
        if (rb != ra) poke(rb, DW'($urandom));
      end
      run_instr(ra, rb, ($urandom % 4 == 0), (ra == rb) ? "R9" : "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule